// File: doc/BRIEF.md
# PCI Target Burst Disconnect Control

This block sits beside a PCI target's address decoder and data path and decides whether a transaction it has claimed may run past its first data phase. At the address phase the decoder presents a region code. The block latches that code and keeps it for the whole transaction. During the data phases it watches the bus handshake lines. For register-type regions it drives STOP# low together with the first TRDY#. That first transfer still completes, and the initiator is told to end the burst there and start a fresh cycle.

Register-type regions are configuration space, the operation registers, and the FIFO port reached as a target. Accesses that decode to one of the base-address memory or I/O windows are never disconnected, so they can burst for as long as the initiator and the data path keep going. The block does not decide when DEVSEL# or TRDY# are asserted. It only adds STOP# on top of the handshake that the data path produces.

Top module: `pci_tgt_burst_stop`

## Requirements
- R1: While reset is held and in the first cycle after it, `stop_n` is high.
- R2: A configuration access (region code 1) whose FRAME# is still low in its first data phase gets `stop_n` low in the same cycle as TRDY# is first low.
- R3: An operation-register access (code 2) and a FIFO-port access (code 3) are disconnected in the same way as R2.
- R4: Accesses to windows 1 to 4 (codes 4, 5, 6 and 7) never see `stop_n` low, however many data phases the burst has.
- R5: During target wait states of the first data phase (TRDY# high), `stop_n` stays high. It is never asserted before TRDY#, so the first transfer completes with data.
- R6: Once asserted, `stop_n` stays low for as long as FRAME# is low, even after TRDY# goes high. It goes high in the cycle after the first clock edge that samples FRAME# high.
- R7: If FRAME# is already high in the first data phase (a single transfer), `stop_n` is not asserted.
- R8: The region code is sampled only at the address phase, which is marked by `addr_phase` high. Changes on `region` during data phases do not change the `stop_n` behaviour of that transaction.
- R9: Region code 0 means that no region was claimed. Such a transaction never asserts `stop_n`.
- R10: If the initiator inserts wait states (IRDY# high) while TRDY# is low in the first data phase of a register access, `stop_n` stays low through those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_phase | input | 1 | High during the address phase of a transaction claimed by this target |
| region | input | RGN_W | Decoded region code, valid while `addr_phase` is high |
| frame_n | input | 1 | FRAME# from the bus |
| irdy_n | input | 1 | IRDY# from the bus |
| trdy_n | input | 1 | TRDY# as driven by this target's data path |
| stop_n | output | 1 | STOP# to be driven by this target |

## Verification
The assertions assume legal bus behaviour. `addr_phase` is raised only in a cycle where FRAME# is low and no transaction is in progress, and an initiator does not restart FRAME# before the previous transaction has ended with FRAME# and IRDY# both high. The directed tasks drive only such sequences: an address cycle, optional target or initiator wait states, the data phases, and an idle cycle before the next address phase. The only deliberately irregular stimulus is garbage on `region` during data phases, which the design must ignore.

// File: rtl/pci_disc_pkg.sv
package pci_disc_pkg;

   localparam int unsigned RGN_NONE  = 0;
   localparam int unsigned RGN_CFG   = 1;
   localparam int unsigned RGN_OPREG = 2;
   localparam int unsigned RGN_FIFO  = 3;
   localparam int unsigned RGN_WIN0  = 4;

   typedef struct packed {
      logic claimed;
      logic no_burst;
   } rgn_class_t;

endpackage

// File: rtl/pbs_rgn_decode.sv
module pbs_rgn_decode
   import pci_disc_pkg::*;
#(
   parameter int unsigned RGN_W   = 3,
   parameter int unsigned NUM_WIN = 4
) (
   input  logic [RGN_W-1:0] region,
   output rgn_class_t       cls
);

   localparam int unsigned LAST_CODE = RGN_WIN0 + NUM_WIN - 1;

   initial begin
      if (NUM_WIN < 1)
         $error("pbs_rgn_decode: NUM_WIN must be at least 1");
      if (LAST_CODE >= (1 << RGN_W))
         $error("pbs_rgn_decode: RGN_W too narrow for %0d windows", NUM_WIN);
   end

   logic [NUM_WIN-1:0] win_hit;

   generate
      for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
         assign win_hit[gi] = (region == RGN_W'(RGN_WIN0 + gi));
      end
   endgenerate

   logic reg_hit;
   assign reg_hit = (region == RGN_W'(RGN_CFG))
                 || (region == RGN_W'(RGN_OPREG))
                 || (region == RGN_W'(RGN_FIFO));

   always_comb begin
      cls.no_burst = reg_hit;
      cls.claimed  = reg_hit || (|win_hit);
   end

   always_comb begin
      assert_onehot_win_R4: assert ($onehot0(win_hit));
   end

endmodule

// File: rtl/pbs_txn_track.sv
module pbs_txn_track
   import pci_disc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       addr_phase,
   input  rgn_class_t cls_in,
   input  logic       frame_n,
   input  logic       irdy_n,
   input  logic       trdy_n,
   input  logic       stop_n,
   output logic       active,
   output logic       first_dp,
   output rgn_class_t cls_q
);

   logic txn_end;
   logic dp_done;

   assign txn_end = active && frame_n && irdy_n;
   assign dp_done = first_dp && !irdy_n && (!trdy_n || !stop_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         first_dp <= 1'b0;
         cls_q    <= '0;
      end else if (addr_phase) begin
         active   <= cls_in.claimed;
         first_dp <= cls_in.claimed;
         cls_q    <= cls_in;
      end else if (txn_end) begin
         active   <= 1'b0;
         first_dp <= 1'b0;
      end else if (dp_done) begin
         first_dp <= 1'b0;
      end
   end

   assert_addr_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      addr_phase |-> !frame_n);

   assert_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !addr_phase && !txn_end) |=> $stable(cls_q));

   assert_first_in_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      first_dp |-> active);

endmodule

// File: rtl/pbs_stop_gen.sv
module pbs_stop_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic first_dp,
   input  logic no_burst,
   input  logic frame_n,
   input  logic trdy_n,
   output logic stop_n
);

   logic stop_now;
   logic hold_q;

   assign stop_now = active && first_dp && no_burst && !frame_n && !trdy_n;
   assign stop_n   = !(stop_now || hold_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= (stop_now || hold_q) && !frame_n;
   end

   assert_stop_with_trdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_n) |-> !trdy_n);

   assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_n && frame_n) |=> stop_n);

   assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (first_dp && frame_n && $past(stop_n)) |-> stop_n);

endmodule

// File: rtl/pci_tgt_burst_stop.sv
module pci_tgt_burst_stop
   import pci_disc_pkg::*;
#(
   parameter int unsigned RGN_W   = 3,
   parameter int unsigned NUM_WIN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_phase,
   input  logic [RGN_W-1:0] region,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic             trdy_n,
   output logic             stop_n
);

   rgn_class_t cls_in;
   rgn_class_t cls_q;
   logic       active;
   logic       first_dp;

   pbs_rgn_decode #(.RGN_W(RGN_W), .NUM_WIN(NUM_WIN)) u_dec (
      .region (region),
      .cls    (cls_in)
   );

   pbs_txn_track u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_phase (addr_phase),
      .cls_in     (cls_in),
      .frame_n    (frame_n),
      .irdy_n     (irdy_n),
      .trdy_n     (trdy_n),
      .stop_n     (stop_n),
      .active     (active),
      .first_dp   (first_dp),
      .cls_q      (cls_q)
   );

   pbs_stop_gen u_stop (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (active),
      .first_dp (first_dp),
      .no_burst (cls_q.no_burst),
      .frame_n  (frame_n),
      .trdy_n   (trdy_n),
      .stop_n   (stop_n)
   );

   assert_window_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !cls_q.no_burst) |-> stop_n);

   assert_stop_reg_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_n |-> cls_q.no_burst);

   assert_unclaimed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (stop_n || !frame_n));

endmodule

// File: tb/pci_tgt_burst_stop_bench.sv
`timescale 1ns/100ps
module pci_tgt_burst_stop_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       addr_phase;
   logic [2:0] region;
   logic       frame_n, irdy_n, trdy_n;
   logic       stop_n;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pci_tgt_burst_stop u_pci_tgt_burst_stop (
      .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .region(region),
      .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .stop_n(stop_n)
   );

   task automatic check(input string req, input logic exp);
      n_run++;
      if (stop_n !== exp) begin
         n_fail++;
         $display("FAIL %s: stop_n=%b expected %b at %0t", req, stop_n, exp, $time);
      end
   endtask

   // drive one cycle at negedge, sample 1 ns later
   task automatic cyc(input logic av, input logic [2:0] rg,
                      input logic f, input logic i, input logic t);
      @(negedge clk);
      addr_phase = av; region = rg; frame_n = f; irdy_n = i; trdy_n = t;
      #1;
   endtask

   task automatic idle();
      cyc(1'b0, 3'd0, 1'b1, 1'b1, 1'b1);
   endtask

   // register access with burst attempt; tw target waits, iw initiator waits
   task automatic reg_burst(input string req, input logic [2:0] rg,
                            input int tw, input int iw, input logic [2:0] junk);
      cyc(1'b1, rg, 1'b0, 1'b1, 1'b1);
      check(req, 1'b1);
      for (int k = 0; k < tw; k++) begin
         cyc(1'b0, junk, 1'b0, 1'b0, 1'b1);
         check("R5", 1'b1);
      end
      for (int k = 0; k < iw; k++) begin
         cyc(1'b0, junk, 1'b0, 1'b1, 1'b0);
         check("R10", 1'b0);
      end
      cyc(1'b0, junk, 1'b0, 1'b0, 1'b0);
      check(req, 1'b0);
      cyc(1'b0, junk, 1'b0, 1'b1, 1'b1);   // initiator lingers with FRAME# low
      check("R6", 1'b0);
      cyc(1'b0, junk, 1'b1, 1'b0, 1'b1);
      check("R6", 1'b0);
      idle();
      check("R6", 1'b1);
      idle();
      check("R6", 1'b1);
   endtask

   task automatic win_burst(input string req, input logic [2:0] rg,
                            input int n, input logic [2:0] junk);
      cyc(1'b1, rg, 1'b0, 1'b1, 1'b1);
      check(req, 1'b1);
      for (int k = 0; k < n; k++) begin
         cyc(1'b0, junk, 1'b0, 1'b0, 1'b0);
         check(req, 1'b1);
      end
      cyc(1'b0, junk, 1'b1, 1'b0, 1'b0);
      check(req, 1'b1);
      idle();
      check(req, 1'b1);
   endtask

   task automatic single(input string req, input logic [2:0] rg);
      cyc(1'b1, rg, 1'b0, 1'b1, 1'b1);
      cyc(1'b0, rg, 1'b1, 1'b0, 1'b1);
      check("R7", 1'b1);
      cyc(1'b0, rg, 1'b1, 1'b0, 1'b0);
      check(req, 1'b1);
      idle();
      check(req, 1'b1);
   endtask

   initial begin
      rst_n = 1'b0; addr_phase = 1'b0; region = 3'd0;
      frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
      #1 check("R1", 1'b1);
      repeat (3) @(negedge clk);
      check("R1", 1'b1);
      rst_n = 1'b1;
      idle();
      check("R1", 1'b1);

      reg_burst("R2", 3'd1, 0, 0, 3'd1);
      reg_burst("R2", 3'd1, 2, 0, 3'd1);
      reg_burst("R3", 3'd2, 1, 0, 3'd2);
      reg_burst("R3", 3'd3, 0, 2, 3'd3);
      reg_burst("R10", 3'd1, 1, 1, 3'd1);
      reg_burst("R8", 3'd2, 0, 0, 3'd5);   // window code on region mid-txn
      for (int w = 4; w < 8; w++) win_burst("R4", 3'(w), 5, 3'(w));
      win_burst("R8", 3'd6, 3, 3'd1);      // register code mid-txn ignored
      win_burst("R9", 3'd0, 3, 3'd0);
      win_burst("R9", 3'd0, 2, 3'd2);
      single("R7", 3'd1);
      single("R7", 3'd3);
      reg_burst("R2", 3'd1, 0, 0, 3'd0);   // back to back after others

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule